// File: doc/BRIEF.md
# Configurable PAL Output Macrocell

This block is one output cell of a small programmable-logic array. It receives eight product-term results from the AND plane and ORs them into a sum. Three personality bits (two shared by every cell of the device and one local to the cell) choose how that sum reaches the pin and what returns to the array as feedback. A fourth bit, also local, sets the output polarity. The cell can work as a clocked output, as a combinatorial I/O whose enable comes from a product term, as an always-enabled combinatorial output, or as a pure input.

The cell drives a pin value and a tri-state enable, and it returns one feedback bit to the array. In the clocked personality the register stores the polarity-adjusted sum and the pin shows its complement, so the outputs are active low. In the I/O personalities product term 0 becomes the enable and drops out of the sum. The feedback comes from the register, from the cell's own pad or from the neighbouring cell's pad, depending on the personality.

Top module: `pal_macrocell`

## Requirements
- R1: With code (glb_a, glb_b, loc_sel) = (1,0,0), the cell is a combinatorial output. pin_oe is always 1 and, with loc_inv = 0, pin_drive is the OR of all eight terms pt[7:0].
- R2: loc_inv = 1 complements the combinatorial data. In every combinatorial personality pin_drive = (OR of the contributing terms) XOR loc_inv.
- R3: With code (0,1,0), the cell is registered. At each rising clock edge the register takes (OR of pt[7:0]) XOR loc_inv, and after that edge pin_drive equals the complement of the stored bit.
- R4: With code (0,1,0), pin_oe follows ext_oe and fb_out equals the stored register bit.
- R5: With codes (0,1,1) and (1,1,1), the cell is a combinatorial I/O. pin_oe equals pt[0], pin_drive = (OR of pt[7:1]) XOR loc_inv, so pt[0] has no effect on the data, and fb_out equals pad_in.
- R6: With code (1,0,1), the cell is a dedicated input. pin_oe is 0, pin_drive is 0 and fb_out equals adj_pad_in.
- R7: With code (1,0,0), fb_out equals adj_pad_in.
- R8: A synchronous active-high rst clears the register to 0. In the registered personality pin_drive then reads 1 and fb_out reads 0.
- R9: The unused codes (0,0,0), (0,0,1) and (1,1,0) leave the pin undriven: pin_oe = 0 and pin_drive = 0. In these codes fb_out equals pad_in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the register |
| glb_a | input | 1 | First device-wide personality bit |
| glb_b | input | 1 | Second device-wide personality bit |
| loc_sel | input | 1 | Cell-local personality bit |
| loc_inv | input | 1 | Cell-local polarity bit, 1 = invert |
| ext_oe | input | 1 | External output-enable pin, active high |
| pt | input | NUM_PT | Product-term results from the AND plane |
| pad_in | input | 1 | Level observed on this cell's pad |
| adj_pad_in | input | 1 | Level observed on the neighbouring cell's pad |
| pin_drive | output | 1 | Value presented to the pad driver |
| pin_oe | output | 1 | Pad driver enable |
| fb_out | output | 1 | Feedback returned to the AND plane |

## Verification
The hardest case to reach from the ports is the register's content while the cell is in a personality that hides it. The register keeps clocking in those personalities, but neither the pin nor the feedback shows it. The stimulus sets and clears the register under both polarities and reads it back through the pin and the feedback in the same cycles. It then walks every personality code, including the three unused ones, with each of term 0, ext_oe, pad_in and adj_pad_in held opposite to the value that would mask an error. This exposes a wrong enable source or a wrong feedback source as a visible mismatch.

// File: rtl/pal_cell_pkg.sv
package pal_cell_pkg;

    localparam int PT_COUNT = 8;

    typedef enum logic [1:0] {
        OE_FROM_PIN  = 2'd0,
        OE_FROM_TERM = 2'd1,
        OE_FORCE_ON  = 2'd2,
        OE_FORCE_OFF = 2'd3
    } oe_src_e;

    typedef enum logic [1:0] {
        FB_FROM_REG  = 2'd0,
        FB_FROM_PAD  = 2'd1,
        FB_FROM_ADJ  = 2'd2
    } fb_src_e;

    typedef struct packed {
        oe_src_e oe_src;
        fb_src_e fb_src;
        logic    skip_term0;
        logic    use_reg;
        logic    drive_off;
    } cell_ctrl_t;

    function automatic logic apply_polarity(input logic sum, input logic invert);
        return invert ? ~sum : sum;
    endfunction

endpackage

// File: rtl/pal_cell_decode.sv
module pal_cell_decode
    import pal_cell_pkg::*;
(
    input  logic       glb_a,
    input  logic       glb_b,
    input  logic       loc_sel,
    output cell_ctrl_t ctrl
);

    always_comb begin
        ctrl = '{oe_src: OE_FORCE_OFF, fb_src: FB_FROM_PAD,
                 skip_term0: 1'b0, use_reg: 1'b0, drive_off: 1'b1};
        unique case ({glb_a, glb_b, loc_sel})
            3'b010: begin
                ctrl.oe_src    = OE_FROM_PIN;
                ctrl.fb_src    = FB_FROM_REG;
                ctrl.use_reg   = 1'b1;
                ctrl.drive_off = 1'b0;
            end
            3'b011, 3'b111: begin
                ctrl.oe_src     = OE_FROM_TERM;
                ctrl.fb_src     = FB_FROM_PAD;
                ctrl.skip_term0 = 1'b1;
                ctrl.drive_off  = 1'b0;
            end
            3'b100: begin
                ctrl.oe_src    = OE_FORCE_ON;
                ctrl.fb_src    = FB_FROM_ADJ;
                ctrl.drive_off = 1'b0;
            end
            3'b101: begin
                ctrl.oe_src = OE_FORCE_OFF;
                ctrl.fb_src = FB_FROM_ADJ;
            end
            default: begin
                ctrl.oe_src = OE_FORCE_OFF;
                ctrl.fb_src = FB_FROM_PAD;
            end
        endcase
    end

endmodule

// File: rtl/pal_cell_sum.sv
module pal_cell_sum
    import pal_cell_pkg::*;
#(
    parameter int NUM_PT = PT_COUNT
) (
    input  logic [NUM_PT-1:0] pt,
    input  logic              skip_term0,
    input  logic              invert,
    output logic              sum_adj
);

    logic [NUM_PT-1:0] gated;

    for (genvar i = 0; i < NUM_PT; i++) begin : g_term
        if (i == 0) begin : g_shared
            assign gated[i] = pt[i] & ~skip_term0;
        end else begin : g_plain
            assign gated[i] = pt[i];
        end
    end

    assign sum_adj = apply_polarity(|gated, invert);

endmodule

// File: rtl/pal_cell_reg.sv
module pal_cell_reg #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
    import pal_cell_pkg::*;
#(
    parameter int NUM_PT = PT_COUNT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              glb_a,
    input  logic              glb_b,
    input  logic              loc_sel,
    input  logic              loc_inv,
    input  logic              ext_oe,
    input  logic [NUM_PT-1:0] pt,
    input  logic              pad_in,
    input  logic              adj_pad_in,
    output logic              pin_drive,
    output logic              pin_oe,
    output logic              fb_out
);

    cell_ctrl_t ctrl;
    logic       sum_adj;
    logic       reg_q;

    pal_cell_decode u_decode (
        .glb_a   (glb_a),
        .glb_b   (glb_b),
        .loc_sel (loc_sel),
        .ctrl    (ctrl)
    );

    pal_cell_sum #(.NUM_PT(NUM_PT)) u_sum (
        .pt         (pt),
        .skip_term0 (ctrl.skip_term0),
        .invert     (loc_inv),
        .sum_adj    (sum_adj)
    );

    pal_cell_reg #(.WIDTH(1)) u_reg (
        .clk (clk),
        .rst (rst),
        .d   (sum_adj),
        .q   (reg_q)
    );

    always_comb begin
        unique case (ctrl.oe_src)
            OE_FROM_PIN:  pin_oe = ext_oe;
            OE_FROM_TERM: pin_oe = pt[0];
            OE_FORCE_ON:  pin_oe = 1'b1;
            default:      pin_oe = 1'b0;
        endcase
    end

    always_comb begin
        if (ctrl.drive_off)    pin_drive = 1'b0;
        else if (ctrl.use_reg) pin_drive = ~reg_q;
        else                   pin_drive = sum_adj;
    end

    always_comb begin
        unique case (ctrl.fb_src)
            FB_FROM_REG: fb_out = reg_q;
            FB_FROM_ADJ: fb_out = adj_pad_in;
            default:     fb_out = pad_in;
        endcase
    end

endmodule

// File: rtl/pal_macrocell_chk.sv
module pal_macrocell_chk #(
    parameter int NUM_PT = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              glb_a,
    input logic              glb_b,
    input logic              loc_sel,
    input logic              loc_inv,
    input logic              ext_oe,
    input logic [NUM_PT-1:0] pt,
    input logic              pin_drive,
    input logic              pin_oe
);

    logic [2:0] code;
    logic       was_running;

    assign code = {glb_a, glb_b, loc_sel};

    always_ff @(posedge clk) begin
        if (rst) was_running <= 1'b0;
        else     was_running <= 1'b1;
    end

    p_comb_out_enabled_r1: assert property (@(posedge clk) disable iff (rst)
        (code == 3'b100) |-> pin_oe);

    p_reg_capture_r3: assert property (@(posedge clk) disable iff (rst)
        (was_running && code == 3'b010 && $past(code) == 3'b010)
        |-> (pin_drive == ~((|$past(pt)) ^ $past(loc_inv))));

    p_reg_oe_pin_r4: assert property (@(posedge clk) disable iff (rst)
        (code == 3'b010) |-> (pin_oe == ext_oe));

    p_io_oe_term_r5: assert property (@(posedge clk) disable iff (rst)
        (code == 3'b011 || code == 3'b111) |-> (pin_oe == pt[0]));

    p_input_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (code == 3'b101) |-> (!pin_oe && !pin_drive));

    p_unused_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (code == 3'b000 || code == 3'b001 || code == 3'b110) |-> (!pin_oe && !pin_drive));

endmodule

bind pal_macrocell pal_macrocell_chk #(.NUM_PT(NUM_PT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .glb_a     (glb_a),
    .glb_b     (glb_b),
    .loc_sel   (loc_sel),
    .loc_inv   (loc_inv),
    .ext_oe    (ext_oe),
    .pt        (pt),
    .pin_drive (pin_drive),
    .pin_oe    (pin_oe)
);

// File: tb/pal_macrocell_tb.sv
module pal_macrocell_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       glb_a = 1'b0, glb_b = 1'b1, loc_sel = 1'b0, loc_inv = 1'b0;
    logic       ext_oe = 1'b0;
    logic [7:0] pt = 8'h00;
    logic       pad_in = 1'b0, adj_pad_in = 1'b0;
    logic       pin_drive, pin_oe, fb_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [2:0] exp_q[$];
    string      tag_q[$];
    logic       model_reg = 1'b0;

    always #4 clk = ~clk;

    pal_macrocell u_dut (
        .clk(clk), .rst(rst), .glb_a(glb_a), .glb_b(glb_b), .loc_sel(loc_sel),
        .loc_inv(loc_inv), .ext_oe(ext_oe), .pt(pt), .pad_in(pad_in),
        .adj_pad_in(adj_pad_in), .pin_drive(pin_drive), .pin_oe(pin_oe), .fb_out(fb_out)
    );

    // Expected {drive, oe, fb} from the requirement text.
    function automatic logic [2:0] predict(input logic [2:0] c, input logic inv, input logic eoe,
                                           input logic [7:0] t, input logic pad,
                                           input logic adj, input logic q);
        logic d, o, f;
        case (c)
            3'b010:         begin d = ~q;                 o = eoe;  f = q;   end
            3'b011, 3'b111: begin d = (|t[7:1]) ^ inv;    o = t[0]; f = pad; end
            3'b100:         begin d = (|t) ^ inv;         o = 1'b1; f = adj; end
            3'b101:         begin d = 1'b0;               o = 1'b0; f = adj; end
            default:        begin d = 1'b0;               o = 1'b0; f = pad; end
        endcase
        return {d, o, f};
    endfunction

    task automatic step(input logic r, input logic [2:0] c, input logic inv, input logic eoe,
                        input logic [7:0] t, input logic pad, input logic adj, input string tag);
        @(negedge clk);
        rst = r; {glb_a, glb_b, loc_sel} = c; loc_inv = inv; ext_oe = eoe;
        pt = t; pad_in = pad; adj_pad_in = adj;
        if (r) model_reg = 1'b0;
        else if (c == 3'b011 || c == 3'b111) model_reg = (|t[7:1]) ^ inv;
        else model_reg = (|t) ^ inv;
        exp_q.push_back(predict(c, inv, eoe, t, pad, adj, model_reg));
        tag_q.push_back(tag);
    endtask

    initial begin : monitor
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [2:0] e;
                string      tg;
                e  = exp_q.pop_front();
                tg = tag_q.pop_front();
                checks++;
                if ({pin_drive, pin_oe, fb_out} !== e) begin
                    failures++;
                    $display("FAIL %s: {drive,oe,fb} got %b expected %b", tg,
                             {pin_drive, pin_oe, fb_out}, e);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : driver
        // R8: reset clears register; registered pin reads high
        step(1, 3'b010, 0, 1, 8'hFF, 0, 1, "R8 reset state");
        step(1, 3'b010, 1, 0, 8'h00, 1, 0, "R8 reset held");
        // R3/R4: registered capture and enable from pin
        step(0, 3'b010, 0, 1, 8'h10, 0, 0, "R3 capture one");
        step(0, 3'b010, 0, 0, 8'h00, 1, 1, "R3 capture zero, R4 oe off");
        step(0, 3'b010, 1, 1, 8'h00, 0, 0, "R3 inverted capture");
        step(0, 3'b010, 1, 1, 8'h80, 1, 1, "R4 fb from register");
        step(1, 3'b010, 1, 1, 8'h80, 0, 0, "R8 reset after activity");
        // R1/R2/R7: combinatorial output
        step(0, 3'b100, 0, 0, 8'h01, 0, 1, "R1 term0 counts");
        step(0, 3'b100, 0, 0, 8'h00, 1, 0, "R1 all low, R7 fb adj");
        step(0, 3'b100, 1, 0, 8'h00, 0, 1, "R2 invert empty sum");
        step(0, 3'b100, 1, 0, 8'h42, 1, 0, "R2 invert busy sum");
        // R5: combinatorial I/O, both codes
        step(0, 3'b011, 0, 0, 8'h01, 1, 0, "R5 term0 enables but not data");
        step(0, 3'b011, 0, 0, 8'h20, 0, 1, "R5 disabled, data high");
        step(0, 3'b111, 1, 1, 8'h03, 0, 1, "R5 inverted, enabled");
        step(0, 3'b111, 0, 1, 8'h00, 1, 0, "R5 fb own pad");
        // R6: dedicated input
        step(0, 3'b101, 0, 1, 8'hFF, 0, 1, "R6 input ignores terms");
        step(0, 3'b101, 1, 1, 8'h01, 1, 0, "R6 input fb adj");
        // R9: unused codes
        step(0, 3'b000, 0, 1, 8'hFF, 1, 0, "R9 code 000");
        step(0, 3'b001, 1, 1, 8'h01, 0, 1, "R9 code 001");
        step(0, 3'b110, 0, 1, 8'h81, 1, 0, "R9 code 110");
        // R3 after other modes: register kept clocking
        step(0, 3'b010, 0, 1, 8'h04, 0, 1, "R3 return to registered");
        repeat (3) @(posedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule